// File: doc/BRIEF.md
# Dual Backup Source Selector

This block picks which of two backup energy sources feeds the memory supply rail while main power is absent, and decides whether the sources may be connected at all. It compares digitised voltage codes for both sources while main power is down. It begins each outage on source 1 and moves to the other source only when that one is higher by more than a hysteresis margin code. As the sources drain unevenly, the selection alternates between them.

To avoid draining a battery when no data needs keeping, both sources start isolated. An insertion strobe for either battery isolates them again. A qualified isolation request during the early part of a power-down does the same. Once isolated, the sources reconnect only after main power has been applied and then removed again. Analog measurement, the power switch itself and detection of the mid-level request pulse are handled elsewhere. This block takes the digital results.

Top module: `backup_src_sel`

## Requirements
- R1: After reset, and in the cycle after either insertion strobe (`bat1_ins_i` or `bat2_ins_i`) is high, `link_en_o` is 0 (both sources isolated).
- R2: While isolated, `link_en_o` goes to 1 only in the cycle after `main_ok_i` falls from 1 to 0, and only if `main_ok_i` has been 1 at some point since the isolation. An outage that is already running when isolation happens does not reconnect.
- R3: In the cycle after `main_ok_i` falls from 1 to 0, `src_sel_o` is 0 (source 1), whatever it was before.
- R4: Inside the comparison window, `src_sel_o` moves from 0 to 1 only when `src2_i - src1_i` is strictly greater than `margin_i`. A difference equal to the margin keeps 0.
- R5: Inside the comparison window, `src_sel_o` moves from 1 to 0 only when `src1_i - src2_i` is strictly greater than `margin_i`.
- R6: The comparison window opens on the fall of `main_ok_i`. It closes after `below_so_i` has been 1 and then returns to 0, or when `main_ok_i` returns to 1. Outside the window, `src_sel_o` holds its value.
- R7: `iso_req_i` held high for `HOLD_CYC` consecutive cycles inside the request window isolates the sources (`link_en_o` becomes 0 in the cycle after the last of those cycles). The request window is: `main_ok_i` is 0, `below_so_i` is 0, and `below_so_i` has not yet been 1 in this outage. A shorter pulse is ignored.
- R8: `iso_req_i` is ignored once `below_so_i` has been 1 in the current outage.
- R9: Both outputs are registered. Each responds in the cycle after the input that causes the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src1_i | input | W | Source 1 voltage code, unsigned |
| src2_i | input | W | Source 2 voltage code, unsigned |
| margin_i | input | W | Hysteresis margin code |
| main_ok_i | input | 1 | Main power above the power-fail threshold |
| below_so_i | input | 1 | Main power below the switchover level |
| iso_req_i | input | 1 | Isolation request level, already detected |
| bat1_ins_i | input | 1 | Battery 1 insertion strobe |
| bat2_ins_i | input | 1 | Battery 2 insertion strobe |
| src_sel_o | output | 1 | 0 selects source 1, 1 selects source 2 |
| link_en_o | output | 1 | 1 connects the selected source, 0 isolates both |

## Verification
The selector is driven with source codes whose difference lies below, exactly at and just above the margin, in both directions. This separates a strict compare from an inclusive one and shows that the selection alternates rather than sticking. Source codes that change after the window closes show whether the selection holds outside the window. A second outage that opens while source 2 is selected shows that each outage restarts on source 1. Isolation requests are given as a pulse one cycle too short, as a pulse of exactly the hold length, and as a long pulse after `below_so_i` has been seen. These separate the qualifier length from the window gating. Insertion strobes for each battery, followed by apply-and-remove cycles, exercise the reconnect path.

// File: rtl/bss_pkg.sv
package bss_pkg;
  typedef enum logic [1:0] {
    LINK_WAIT_UP   = 2'd0,
    LINK_WAIT_DOWN = 2'd1,
    LINK_ON        = 2'd2
  } link_state_e;
endpackage

// File: rtl/bss_window.sv
module bss_window (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic main_ok_i,
  input  logic below_so_i,
  output logic start_o,
  output logic win_o,
  output logic seen_o
);
  logic main_q, win_q, seen_q;

  assign start_o = main_q & ~main_ok_i;
  assign win_o   = win_q;
  assign seen_o  = seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q <= 1'b0;
      win_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      main_q <= main_ok_i;
      if (start_o) begin
        win_q  <= 1'b1;
        seen_q <= 1'b0;
      end else if (win_q) begin
        if (main_ok_i || (seen_q && !below_so_i)) win_q <= 1'b0;
        seen_q <= seen_q | below_so_i;
      end
    end
  end

  // R6
  win_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_q && main_ok_i) |=> !win_q);
  // R6
  win_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(win_q) |-> $past(start_o));
endmodule

// File: rtl/bss_picker.sv
module bss_picker #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         win_i,
  input  logic [W-1:0] src1_i,
  input  logic [W-1:0] src2_i,
  input  logic [W-1:0] margin_i,
  output logic         sel_o
);
  logic sel_q;
  logic to_two, to_one;
  logic [W-1:0] d21, d12;

  assign d21    = src2_i - src1_i;
  assign d12    = src1_i - src2_i;
  assign to_two = (src2_i > src1_i) && (d21 > margin_i);
  assign to_one = (src1_i > src2_i) && (d12 > margin_i);
  assign sel_o  = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               sel_q <= 1'b0;
    else if (start_i)          sel_q <= 1'b0;
    else if (win_i && !sel_q)  sel_q <= to_two;
    else if (win_i && sel_q)   sel_q <= !to_one;
  end

  // R3
  restart_src1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sel_q);
  // R6
  hold_outside_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!win_i && !start_i) |=> $stable(sel_q));
  // R4
  up_needs_margin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_q) |-> ($past(src2_i) > $past(src1_i)));
  // R5
  down_needs_margin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sel_q) && !$past(start_i)) |-> ($past(src1_i) > $past(src2_i)));
endmodule

// File: rtl/bss_isolator.sv
module bss_isolator #(
  parameter int HOLD_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic seen_i,
  input  logic main_ok_i,
  input  logic below_so_i,
  input  logic iso_req_i,
  input  logic ins_i,
  output logic link_o
);
  import bss_pkg::*;
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  link_state_e st_q;
  logic [CW-1:0] cnt_q;
  logic req_win, req_ok;

  assign req_win = ~main_ok_i & ~below_so_i & ~seen_i;
  assign req_ok  = iso_req_i & req_win & (cnt_q == LAST);
  assign link_o  = (st_q == LINK_ON);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!(iso_req_i && req_win)) cnt_q <= '0;
    else if (cnt_q != LAST)         cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  st_q <= LINK_WAIT_UP;
    else if (ins_i || req_ok)     st_q <= LINK_WAIT_UP;
    else begin
      case (st_q)
        LINK_WAIT_UP:   if (main_ok_i) st_q <= LINK_WAIT_DOWN;
        LINK_WAIT_DOWN: if (start_i)   st_q <= LINK_ON;
        default:        st_q <= LINK_ON;
      endcase
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R1
  ins_isolate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_i |=> !link_o);
  // R2
  reconnect_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(link_o) |-> ($past(start_i) && !$past(main_ok_i)));
endmodule

// File: rtl/backup_src_sel.sv
module backup_src_sel #(
  parameter int W        = 8,
  parameter int HOLD_CYC = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src1_i,
  input  logic [W-1:0] src2_i,
  input  logic [W-1:0] margin_i,
  input  logic         main_ok_i,
  input  logic         below_so_i,
  input  logic         iso_req_i,
  input  logic         bat1_ins_i,
  input  logic         bat2_ins_i,
  output logic         src_sel_o,
  output logic         link_en_o
);
  logic start, win, seen;

  bss_window u_window (
    .clk_i, .rst_ni, .main_ok_i, .below_so_i,
    .start_o(start), .win_o(win), .seen_o(seen)
  );

  bss_picker #(.W(W)) u_picker (
    .clk_i, .rst_ni, .start_i(start), .win_i(win),
    .src1_i, .src2_i, .margin_i, .sel_o(src_sel_o)
  );

  bss_isolator #(.HOLD_CYC(HOLD_CYC)) u_isolator (
    .clk_i, .rst_ni, .start_i(start), .seen_i(seen),
    .main_ok_i, .below_so_i, .iso_req_i,
    .ins_i(bat1_ins_i | bat2_ins_i), .link_o(link_en_o)
  );
endmodule

// File: tb/backup_src_sel_bench.sv
module backup_src_sel_bench;
  localparam int W = 8;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] s1 = 8'd100, s2 = 8'd100, mg = 8'd10;
  logic mok = 1'b1, bso = 1'b0, iso = 1'b0, i1 = 1'b0, i2 = 1'b0;
  logic sel, lnk;

  typedef struct { logic sel; logic lnk; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  backup_src_sel #(.W(W), .HOLD_CYC(HOLD)) u_backup_src_sel (
    .clk_i(clk), .rst_ni(rst_n), .src1_i(s1), .src2_i(s2), .margin_i(mg),
    .main_ok_i(mok), .below_so_i(bso), .iso_req_i(iso),
    .bat1_ins_i(i1), .bat2_ins_i(i2), .src_sel_o(sel), .link_en_o(lnk)
  );

  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic m, input logic so, input logic rq,
                      input logic n1, input logic n2,
                      input logic es, input logic el, input string tag);
    exp_t e;
    @(posedge clk); #2;
    s1 = a; s2 = b; mok = m; bso = so; iso = rq; i1 = n1; i2 = n2;
    e.sel = es; e.lnk = el; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (sel !== e.sel || lnk !== e.lnk) begin
          errors++;
          $display("FAIL %s: sel=%b link=%b expected sel=%b link=%b",
                   e.tag, sel, lnk, e.sel, e.lnk);
        end
      end
    end
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    #1; checks++;
    if (sel !== 1'b0 || lnk !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: sel=%b link=%b expected sel=0 link=0", sel, lnk);
    end
    //    s1   s2   mok so rq n1 n2 sel lnk
    step(100, 100, 1, 0, 0, 0, 0, 0, 0, "R1 isolated while powered");
    step(100, 120, 0, 0, 0, 0, 0, 0, 1, "R2 connect on main fall / R3 start src1");
    step(100, 120, 0, 0, 0, 0, 0, 1, 1, "R4 diff 20 above margin");
    step(125, 120, 0, 0, 0, 0, 0, 1, 1, "R5 diff 5 keeps src2");
    step(130, 120, 0, 0, 0, 0, 0, 1, 1, "R5 diff equal margin keeps src2");
    step(131, 120, 0, 0, 0, 0, 0, 0, 1, "R5 diff 11 back to src1");
    step(100, 110, 0, 0, 0, 0, 0, 0, 1, "R4 diff equal margin keeps src1");
    step(100, 111, 0, 0, 0, 0, 0, 1, 1, "R4 diff 11 alternates to src2");
    step(100, 111, 0, 1, 0, 0, 0, 1, 1, "R6 below switchover still in window");
    step(100, 111, 0, 0, 0, 0, 0, 1, 1, "R6 window closing edge");
    step(150, 111, 0, 0, 0, 0, 0, 1, 1, "R6 hold outside window");
    step(150, 111, 1, 0, 0, 0, 0, 1, 1, "R6 main back, hold");
    step(150, 111, 0, 0, 0, 0, 0, 0, 1, "R3 new outage restarts on src1");
    step(150, 111, 0, 0, 0, 0, 0, 0, 1, "R4 src1 higher stays");
    for (int k = 0; k < HOLD - 1; k++)
      step(150, 111, 0, 0, 1, 0, 0, 0, 1, "R7 short request pending");
    step(150, 111, 0, 0, 0, 0, 0, 0, 1, "R7 short request ignored");
    for (int k = 0; k < HOLD - 1; k++)
      step(150, 111, 0, 0, 1, 0, 0, 0, 1, "R7 request counting");
    step(150, 111, 0, 0, 1, 0, 0, 0, 0, "R7 full request isolates");
    step(150, 111, 0, 0, 0, 0, 0, 0, 0, "R2 stays isolated during outage");
    step(150, 111, 1, 0, 0, 0, 0, 0, 0, "R2 main applied, still isolated");
    step(150, 111, 0, 0, 0, 0, 0, 0, 1, "R2 reconnect after apply and remove");
    step(150, 111, 0, 0, 0, 1, 0, 0, 0, "R1 battery 1 insertion isolates");
    step(150, 111, 1, 0, 0, 0, 0, 0, 0, "R1 insertion, main applied");
    step(50, 200, 0, 0, 0, 0, 0, 0, 1, "R2 reconnect after insertion");
    step(50, 200, 0, 0, 0, 0, 0, 1, 1, "R9 select after one cycle");
    step(50, 200, 0, 1, 0, 0, 0, 1, 1, "R8 below switchover seen");
    for (int k = 0; k < HOLD + 1; k++)
      step(50, 200, 0, 1, 1, 0, 0, 1, 1, "R8 late request ignored");
    step(50, 200, 0, 1, 0, 0, 1, 1, 0, "R1 battery 2 insertion isolates");
    step(50, 200, 0, 1, 0, 0, 0, 1, 0, "R2 no reconnect without main");
    @(posedge clk); @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule